// File: doc/BRIEF.md
# Fractional Audio Bit-Clock Divider

This block derives an audio bit clock from a single, faster reference clock. The division ratio has an integer part and a fractional part with a step of 1/512. A fixed divide-by-two is built in, so the output runs at `f_ref / (2 × (N + F/512))`, where N is the integer part and F is the fractional part.

Each half-period of the output lasts either N or N+1 reference cycles. A 9-bit phase accumulator makes this choice: it gains F at every half-period boundary, and a carry out of it lengthens the next half-period by one cycle. The block therefore reaches any audio sample rate from one fixed reference, and the average period matches the formula exactly.

The block also gives a one-cycle tick that marks every change of the bit clock, for a serializer to use. The clock-enable input and the slave-mode input both stop the block. While stopped, the output stays low and the internal state is cleared.

Top module: `frac_bclk_div`

## Requirements
- R1: While `clk_en` is 0, `bclk_o` is low one cycle later and stays low, and `edge_tick_o` stays 0.
- R2: While `slave_mode` is 1, the block behaves as disabled, whatever the value of `clk_en`. Setting `slave_mode` during a run forces `bclk_o` low on the next cycle.
- R3: With `div_frac` = 0 and `div_int` = N ≥ 2, every half-period of `bclk_o` lasts exactly N reference cycles.
- R4: The accumulator is FRAC_W bits wide and starts at 0 when the block is enabled. It adds `div_frac` once per half-period. A half-period lasts N+1 cycles exactly when that addition carries out, and N cycles otherwise. Over 512 half-periods the total is 512·N + F cycles.
- R5: A `div_int` value of 0 or 1 gives half-periods of 2 cycles.
- R6: `edge_tick_o` is 1 for exactly the cycle in which `bclk_o` holds a value different from the one it held in the previous cycle.
- R7: A change to `div_int` or `div_frac` in the middle of a half-period does not alter that half-period. The new value first sets the length of the following half-period.
- R8: Once enabled, the first half-period is low. `bclk_o` first rises one half-period length after the first enabled clock edge. Re-enabling after a disable restarts the whole sequence from accumulator value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_int | input | INT_W | Integer part of the half-period length |
| div_frac | input | FRAC_W | Fractional part, in 1/512 steps |
| clk_en | input | 1 | Enables the divider |
| slave_mode | input | 1 | When 1, the divider is stopped |
| bclk_o | output | 1 | Bit clock output |
| edge_tick_o | output | 1 | One-cycle pulse marking each change of `bclk_o` |

## Verification
The bench uses the default widths, INT_W = 10 and FRAC_W = 9. The carry point is therefore the real 512-step one. A full accumulator cycle of 512 half-periods is run with F = 511, and the summed length is compared with 512·N + F. The 10-bit integer field puts the clamp of N = 0 and N = 1 within reach, and short runs at several fractions check the carry pattern of every half-period against a bench model.

// File: rtl/frac_bclk_div.sv
module frac_bclk_div #(
  parameter int INT_W  = 10,
  parameter int FRAC_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  input  logic              clk_en,
  input  logic              slave_mode,
  output logic              bclk_o,
  output logic              edge_tick_o
);
  localparam int LEN_W = INT_W + 1;

  logic [LEN_W-1:0]  cnt_q;
  logic [FRAC_W-1:0] acc_q;
  logic              run_q;

  wire              active   = clk_en & ~slave_mode;
  wire [FRAC_W:0]   sum      = {1'b0, acc_q} + {1'b0, div_frac};
  wire [INT_W-1:0]  base     = (div_int < INT_W'(2)) ? INT_W'(2) : div_int;
  wire [LEN_W-1:0]  len      = {1'b0, base} + LEN_W'(sum[FRAC_W]);
  wire              boundary = ~run_q | (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      acc_q       <= '0;
      run_q       <= 1'b0;
      bclk_o      <= 1'b0;
      edge_tick_o <= 1'b0;
    end else if (!active) begin
      cnt_q       <= '0;
      acc_q       <= '0;
      run_q       <= 1'b0;
      bclk_o      <= 1'b0;
      edge_tick_o <= 1'b0;
    end else if (boundary) begin
      cnt_q       <= len - LEN_W'(1);
      acc_q       <= sum[FRAC_W-1:0];
      run_q       <= 1'b1;
      bclk_o      <= run_q ? ~bclk_o : bclk_o;
      edge_tick_o <= run_q;
    end else begin
      cnt_q       <= cnt_q - LEN_W'(1);
      edge_tick_o <= 1'b0;
    end
  end

  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!bclk_o && !edge_tick_o));

  // R6
  tick_marks_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_tick_o |-> (bclk_o != $past(bclk_o)));

  // R6
  edge_has_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_o != $past(bclk_o)) |-> (edge_tick_o || !bclk_o));

  // R7
  half_unaltered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && run_q && cnt_q != '0) |=> (!run_q || cnt_q == $past(cnt_q) - LEN_W'(1)));

  // R4
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && run_q && cnt_q != '0) |=> (!run_q || acc_q == $past(acc_q)));
endmodule

// File: tb/frac_bclk_div_test.sv
module frac_bclk_div_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] div_int = 10'd5;
  logic [8:0] div_frac = 9'd0;
  logic       clk_en = 1'b0;
  logic       slave_mode = 1'b0;
  logic       bclk_o, edge_tick_o;
  int checks = 0, errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  frac_bclk_div uut (.clk(clk), .rst_n(rst_n), .div_int(div_int), .div_frac(div_frac),
                     .clk_en(clk_en), .slave_mode(slave_mode),
                     .bclk_o(bclk_o), .edge_tick_o(edge_tick_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic next_tick(output int g);
    g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!edge_tick_o && g < 5000);
  endtask

  task automatic half_len(input int n, inout int acc, output int len);
    int b = (n < 2) ? 2 : n;
    acc += div_frac;
    if (acc >= 512) begin acc -= 512; len = b + 1; end
    else len = b;
  endtask

  task automatic stop_run();
    @(negedge clk);
    clk_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset_idle();
    int bad = 0;
    chk(bclk_o == 0 && edge_tick_o == 0, "R1 reset state", bclk_o, 0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (bclk_o || edge_tick_o) bad++;
    end
    chk(bad == 0, "R1 disabled stays low", bad, 0);
  endtask

  task automatic t_slave();
    int bad = 0;
    slave_mode = 1'b1; clk_en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (bclk_o || edge_tick_o) bad++;
    end
    chk(bad == 0, "R2 slave mode silent", bad, 0);
    slave_mode = 1'b0;
    repeat (7) @(negedge clk);
    chk(bclk_o == 1, "R2 running before slave set", bclk_o, 1);
    slave_mode = 1'b1;
    @(negedge clk);
    chk(bclk_o == 0, "R2 slave forces low", bclk_o, 0);
    slave_mode = 1'b0;
    stop_run();
  endtask

  task automatic t_integer();
    int g, bad = 0;
    div_int = 10'd5; div_frac = 9'd0;
    @(negedge clk); clk_en = 1'b1;
    next_tick(g);
    chk(g == 6, "R8 first rise after one half", g, 6);
    chk(bclk_o == 1, "R8 first edge rises", bclk_o, 1);
    for (int i = 0; i < 10; i++) begin
      next_tick(g);
      if (g != 5) bad++;
    end
    chk(bad == 0, "R3 integer half-periods", bad, 0);
    @(negedge clk);
    chk(edge_tick_o == 0, "R6 tick lasts one cycle", edge_tick_o, 0);
    stop_run();
  endtask

  task automatic t_frac(input int n, input int f, input int halves);
    int g, acc = 0, len, bad = 0;
    div_int = n[9:0]; div_frac = f[8:0];
    @(negedge clk); clk_en = 1'b1;
    half_len(n, acc, len);
    next_tick(g);
    chk(g == len + 1, "R4 first fractional half", g, len + 1);
    for (int i = 0; i < halves; i++) begin
      half_len(n, acc, len);
      next_tick(g);
      if (g != len) begin
        bad++;
        if (bad == 1) chk(0, "R4 half length", g, len);
      end
    end
    chk(bad == 0, "R4 carry pattern", bad, 0);
    stop_run();
  endtask

  task automatic t_full_cycle();
    int g, total = 0;
    div_int = 10'd7; div_frac = 9'd511;
    @(negedge clk); clk_en = 1'b1;
    next_tick(g);
    total = g - 1;
    for (int i = 0; i < 511; i++) begin
      next_tick(g);
      total += g;
    end
    chk(total == 512 * 7 + 511, "R4 512-half total", total, 512 * 7 + 511);
    stop_run();
  endtask

  task automatic t_min(input int n);
    int g, bad = 0;
    div_int = n[9:0]; div_frac = 9'd0;
    @(negedge clk); clk_en = 1'b1;
    next_tick(g);
    for (int i = 0; i < 8; i++) begin
      next_tick(g);
      if (g != 2) bad++;
    end
    chk(bad == 0, "R5 minimum half length", bad, 0);
    stop_run();
  endtask

  task automatic t_change();
    int g;
    div_int = 10'd10; div_frac = 9'd0;
    @(negedge clk); clk_en = 1'b1;
    next_tick(g);
    repeat (3) @(negedge clk);
    div_int = 10'd4;
    next_tick(g);
    chk(g == 7, "R7 current half kept", g + 3, 10);
    next_tick(g);
    chk(g == 4, "R7 new value next half", g, 4);
    stop_run();
  endtask

  task automatic t_restart();
    int g;
    div_int = 10'd4; div_frac = 9'd300;
    @(negedge clk); clk_en = 1'b1;
    repeat (13) @(negedge clk);
    clk_en = 1'b0;
    @(negedge clk);
    chk(bclk_o == 0, "R8 disable drives low", bclk_o, 0);
    repeat (3) @(negedge clk);
    clk_en = 1'b1;
    next_tick(g);
    chk(g == 5, "R8 restart first half", g, 5);
    next_tick(g);
    chk(g == 5, "R8 restart carries at second half", g, 5);
    next_tick(g);
    chk(g == 4, "R8 restart third half", g, 4);
    stop_run();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_idle();
    t_slave();
    t_integer();
    t_frac(3, 128, 32);
    t_frac(6, 300, 40);
    t_full_cycle();
    t_min(0);
    t_min(1);
    t_change();
    t_restart();
    done = 1;
  end

  initial begin
    while (!done && cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule